// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a four-beat burst into a synchronous memory. When the load/advance control is low on an enabled clock edge, it captures an external starting address. On each following enabled edge with that control high, it steps to the next beat. Only the two lowest address bits move. The bits above them keep the captured value until the next load.

A select input chooses the order in which the low bits wrap. In linear order the offset counts up by one modulo four from the starting offset. In interleaved order the starting offset is XORed with a beat index that runs 0, 1, 2, 3. When the active-low clock enable is high, every edge is ignored and the current address is held. The block sits between a command decoder and a memory array. It only generates addresses.

Top module: `burst_addr_seq`

## Requirements
- R1: While the reset is asserted, and on the first cycles after it is released, the output address is all zeros; asserting the reset clears the output without waiting for a clock edge.
- R2: On an edge with `clk_en_n` low and `advance` low, `start_addr` is captured, the beat index restarts at 0, and from the next cycle the output equals the captured address. This holds in the middle of a burst as well.
- R3: With `wrap_xor` = 0 (linear), each edge with `clk_en_n` low and `advance` high makes output bits [1:0] equal to the previous value of those bits plus one, modulo 4 (start 1 gives 1, 2, 3, 0).
- R4: With `wrap_xor` = 1 (interleaved), output bits [1:0] equal the captured starting bits [1:0] XOR the beat index 0, 1, 2, 3 (start 2 gives 2, 3, 0, 1).
- R5: Output bits above bit 1 stay equal to the captured address during advances, including when the low bits wrap from 3 to 0.
- R6: Four advances after a load, the output returns to the captured starting address, in either order.
- R7: On an edge with `clk_en_n` high, the output holds its value whatever `advance` and `start_addr` are.
- R8: `wrap_xor` is applied combinationally to the current beat index: changing it between edges changes the output low bits in the same cycle, and does not change the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| advance | input | 1 | Low: load `start_addr`; high: step to the next beat |
| wrap_xor | input | 1 | 0 selects linear order, 1 selects interleaved order |
| start_addr | input | ADDR_W | External starting address |
| beat_addr | output | ADDR_W | Current burst address |

## Verification
Loads and advances are registered once. A stimulus applied before an enabled rising edge is therefore visible on `beat_addr` one nanosecond after that edge, and every table vector is sampled there. An edge with the enable high must leave that same sample unchanged. The order select has no register on its path, so the R8 check flips it between edges and samples after a short settle, with no clock. Reset clears the output at once, but release passes two synchronizer flops. The bench waits beyond those two edges before it issues the first load.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned DEF_ADDR_W = 18;
  localparam int unsigned DEF_BEAT_W = 2;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int unsigned STAGES = burst_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned ADDR_W = burst_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] base_q
);
  logic [ADDR_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (load_en) base_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int unsigned BEAT_W = burst_pkg::DEF_BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);
  localparam logic [BEAT_W-1:0] BEAT_LAST = '1;
  logic [BEAT_W-1:0] beat_d;

  always_comb begin
    beat_d = beat_q;
    if (clear)     beat_d = '0;
    else if (step) beat_d = beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  // R6: a step from the last beat wraps the index back to zero
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && beat_q == BEAT_LAST) |=> (beat_q == '0));
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map #(
  parameter int unsigned BEAT_W = burst_pkg::DEF_BEAT_W
) (
  input  logic [BEAT_W-1:0] start_ofs,
  input  logic [BEAT_W-1:0] beat,
  input  burst_pkg::order_e order,
  output logic [BEAT_W-1:0] cur_ofs
);
  logic [BEAT_W-1:0] lin_ofs;
  logic [BEAT_W-1:0] xor_ofs;

  always_comb begin
    lin_ofs = start_ofs + beat;
    xor_ofs = start_ofs ^ beat;
    cur_ofs = (order == burst_pkg::ORDER_XOR) ? xor_ofs : lin_ofs;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int unsigned ADDR_W      = burst_pkg::DEF_ADDR_W,
  parameter int unsigned BEAT_W      = burst_pkg::DEF_BEAT_W,
  parameter int unsigned SYNC_STAGES = burst_pkg::DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              advance,
  input  logic              wrap_xor,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] beat_addr
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              rst_sync_n;
  logic              enabled;
  logic              do_load;
  logic              do_step;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] cur_ofs;
  burst_pkg::order_e order;

  always_comb begin
    enabled = !clk_en_n;
    do_load = enabled && !advance;
    do_step = enabled && advance;
    order   = burst_pkg::order_e'(wrap_xor);
  end

  burst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (do_load),
    .load_val (start_addr),
    .base_q   (base_q)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clear  (do_load),
    .step   (do_step),
    .beat_q (beat_q)
  );

  burst_offset_map #(.BEAT_W(BEAT_W)) u_map (
    .start_ofs (base_q[BEAT_W-1:0]),
    .beat      (beat_q),
    .order     (order),
    .cur_ofs   (cur_ofs)
  );

  assign beat_addr = {base_q[ADDR_W-1:BEAT_W], cur_ofs};

  // R2: a load shows the captured address on the next cycle
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    do_load |=> (beat_addr == $past(start_addr)));

  // R3: linear steps add one to the low bits, modulo the burst length
  p_lin_step_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (do_step && !wrap_xor) |=>
      (wrap_xor || beat_addr[BEAT_W-1:0] == BEAT_W'($past(beat_addr[BEAT_W-1:0]) + 1'b1)));

  // R5: upper bits never move on a step
  p_upper_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    do_step |=> (beat_addr[ADDR_W-1:BEAT_W] == $past(beat_addr[ADDR_W-1:BEAT_W])));

  // R7: a disabled edge holds the output when the order select is steady
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clk_en_n |=> (!$stable(wrap_xor) || $stable(beat_addr)));

  initial begin
    a_width_r5: assert (HI_W >= 1);
  end
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int unsigned AW = 18;
  localparam int unsigned NV = 16;
  localparam int unsigned VW = 3 + 2 * AW;

  // {clk_en_n, advance, wrap_xor, start_addr, expected beat_addr}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'b000, 18'h12345, 18'h12345},  // R2 load, start offset 1, linear
    {3'b010, 18'h00000, 18'h12346},  // R3
    {3'b010, 18'h00000, 18'h12347},  // R3
    {3'b010, 18'h00000, 18'h12344},  // R3 R5 wrap 3 -> 0
    {3'b010, 18'h00000, 18'h12345},  // R6 back to start
    {3'b001, 18'h00ABE, 18'h00ABE},  // R2 load, start offset 2, interleaved
    {3'b011, 18'h00000, 18'h00ABF},  // R4 2^1
    {3'b011, 18'h00000, 18'h00ABC},  // R4 2^2
    {3'b011, 18'h00000, 18'h00ABD},  // R4 2^3
    {3'b011, 18'h00000, 18'h00ABE},  // R6 back to start
    {3'b111, 18'h3FFFF, 18'h00ABE},  // R7 disabled step
    {3'b101, 18'h3FFFF, 18'h00ABE},  // R7 disabled load
    {3'b011, 18'h00000, 18'h00ABF},  // R4 step resumes at beat 1
    {3'b000, 18'h3FFFF, 18'h3FFFF},  // R2 load mid-burst
    {3'b010, 18'h00000, 18'h3FFFC},  // R5 upper bits held across wrap
    {3'b010, 18'h00000, 18'h3FFFD}   // R3
  };

  logic          clk;
  logic          rst_n;
  logic          clk_en_n;
  logic          advance;
  logic          wrap_xor;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] beat_addr;

  int checks;
  int errors;
  bit done;

  burst_addr_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .advance    (advance),
    .wrap_xor   (wrap_xor),
    .start_addr (start_addr),
    .beat_addr  (beat_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (beat_addr !== exp) begin
      errors++;
      $display("FAIL %s: beat_addr=%h expected=%h", req, beat_addr, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b1; advance = 1'b1; wrap_xor = 1'b0; start_addr = '0;
    #1;
    check("R1", '0);
    repeat (3) tick();
    check("R1", '0);
    rst_n = 1'b1;
    // loads on edges still inside the synchronizer window are discarded
    clk_en_n = 1'b0; advance = 1'b0; start_addr = 18'h2AAAA;
    tick();
    check("R1", '0);
    clk_en_n = 1'b1;
    repeat (3) tick();

    for (int i = 0; i < NV; i++) begin
      {clk_en_n, advance, wrap_xor, start_addr} = VEC[i][VW-1:AW];
      tick();
      check($sformatf("R%0d vector %0d", (i < 5) ? 3 : (i < 10 ? 4 : (i < 12 ? 7 : 5)), i),
            VEC[i][AW-1:0]);
    end

    // R8: order select acts on the current beat without a clock
    clk_en_n = 1'b0; advance = 1'b0; wrap_xor = 1'b0; start_addr = 18'h00005;
    tick();
    check("R2", 18'h00005);
    advance = 1'b1;
    tick();
    check("R3", 18'h00006);
    clk_en_n = 1'b1;
    wrap_xor = 1'b1;
    #1;
    check("R8", 18'h00004);
    wrap_xor = 1'b0;
    #1;
    check("R8", 18'h00006);

    // R1: reset in mid-burst clears at once
    rst_n = 1'b0;
    #0.5;
    check("R1", '0);
    tick();
    check("R1", '0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: done=%0d expected=1", done);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule